// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block executes one word-sized load or store instruction at a time. It takes a 32-bit instruction word, the address that word was fetched from and the current NZCV flags. It tests the instruction's condition against the flags and forms the effective address from a base register and an offset. The offset is either a 12-bit immediate or an index register shifted left, and it can be added or subtracted. The block then issues one single-cycle memory request. A load writes the returned word into the data register. When the addressing mode asks for it, the updated address is written back into the base register.

A sixteen-entry register file lives inside the block. Entry 15 stands for the program counter: reading it yields the instruction address plus 8, and writes to it are discarded. Instructions enter through a valid/ready handshake. Completion is signalled by a one-cycle `done` pulse, and the next instruction can be offered in that same cycle. The memory side has a fixed latency of one cycle: read data is valid in the cycle that follows the request.

Top module: `ldst_agu`

## Requirements
- R1: `in_ready` is high only while the unit is idle. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. For an executed instruction, `done` is high for exactly one cycle, two cycles after the cycle in which `mem_req` was high, and `in_ready` is high again in that same cycle.
- R2: The instruction fields are placed as follows: condition [31:28], I [25], P [24], U [23], W [21], L [20], base register [19:16], data register [15:12], immediate [11:0], shift amount [11:7], index register [3:0]. Bits [27:26], [22] and [6:4] have no effect.
- R3: With I=0 the offset is the zero-extended 12-bit immediate. With U=1 the offset is added to the base; with U=0 it is subtracted from the base.
- R4: With I=1 the offset is the index register value shifted left logically by bits [11:7].
- R5: With P=1 the access uses base±offset. If W=1, that same address is then written into the base register; if W=0, the base register is left unchanged.
- R6: With P=0 the access uses the unmodified base value. Afterwards the base register receives base±offset, whatever the value of W.
- R7: Register number 15 reads as `instr_addr + 8` wherever it is used: as base, as index, or as store data.
- R8: A load (L=1) drives `mem_we`=0 and writes `mem_rdata`, sampled in the cycle after the request, into the data register. A store (L=0) drives `mem_we`=1, with `mem_wdata` equal to the data register's value.
- R9: When a load's data register is also its writeback base register, the register ends up holding the loaded word.
- R10: The condition codes are: 0 EQ (Z), 1 NE, 2 CS (C), 3 CC, 4 MI (N), 5 PL, 6 VS (V), 7 VC, 8 HI (C and not Z), 9 LS, 10 GE (N=V), 11 LT, 12 GT (not Z and N=V), 13 LE, 14 and 15 always. The flag input is ordered {N,Z,C,V}. A failing condition produces no memory request and no register write, and `done` pulses in the second cycle after acceptance.
- R11: A load into register 15, or a writeback to base register 15, changes no register.
- R12: `mem_req` is high for exactly one cycle per executed instruction. That is the cycle after the edge that follows acceptance, and `mem_addr`, `mem_we` and `mem_wdata` are valid during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, can accept |
| instr | input | 32 | Load/store instruction word |
| instr_addr | input | 32 | Address of the instruction |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid the cycle after `mem_req` |

## Verification
Most internal faults surface on `mem_addr` or `mem_wdata`, and usually within one instruction. A wrong offset, sign or shift, or a wrong choice between the updated address and the base, shows up directly in the address of the request cycle. A missed or misdirected writeback, or a lost load, corrupts a register. That register is exposed the next time it serves as a base, an index or store data. A closing series of stores dumps every register, so no such corruption stays hidden until the end of the run. Handshake and condition faults move or suppress `mem_req` and `done`, and the bench samples those in fixed cycles.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned RIDX_W = 4;
  localparam logic [RIDX_W-1:0] PC_IDX = 4'd15;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_MEM, ST_RESP} agu_state_e;

  typedef struct packed {
    logic              cond_ok;
    logic              reg_off;
    logic              pre;
    logic              up;
    logic              wb;
    logic              load;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rm;
    logic [11:0]       imm;
    logic [4:0]        shamt;
  } agu_fields_t;

  // flags = {N,Z,C,V}
  function automatic logic cond_check(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, r;
    {n, z, cy, v} = f;
    unique case (c[3:1])
      3'd0: r = z;
      3'd1: r = cy;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cy & ~z;
      3'd5: r = (n == v);
      3'd6: r = ~z & (n == v);
      default: r = 1'b1;
    endcase
    if (c[3:1] != 3'd7 && c[0]) r = ~r;
    return r;
  endfunction
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [31:0]  instr,
  input  logic [3:0]   flags,
  output agu_fields_t  fld
);
  logic unused_bits;
  assign unused_bits = ^{instr[27:26], instr[22], instr[6:4]};

  always_comb begin
    fld.cond_ok = cond_check(instr[31:28], flags);
    fld.reg_off = instr[25];
    fld.pre     = instr[24];
    fld.up      = instr[23];
    fld.wb      = instr[21];
    fld.load    = instr[20];
    fld.rn      = instr[19:16];
    fld.rd      = instr[15:12];
    fld.rm      = instr[3:0];
    fld.imm     = instr[11:0];
    fld.shamt   = instr[11:7];
  end
endmodule

// File: rtl/agu_addr.sv
module agu_addr #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] index,
  input  logic         reg_off,
  input  logic         up,
  input  logic         pre,
  input  logic [11:0]  imm,
  input  logic [4:0]   shamt,
  output logic [W-1:0] access_addr,
  output logic [W-1:0] updated_addr
);
  logic [W-1:0] offset;

  always_comb begin
    offset       = reg_off ? (index << shamt) : W'(imm);
    updated_addr = up ? (base + offset) : (base - offset);
    access_addr  = pre ? updated_addr : base;
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int unsigned W      = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned AW    = $clog2(ENTRIES),
  localparam logic [AW-1:0] PCI = AW'(ENTRIES - 1)
) (
  input  logic          clk,
  input  logic [W-1:0]  pc_view,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd_a = (ra_a == PCI) ? pc_view : mem[ra_a];
  assign rd_b = (ra_b == PCI) ? pc_view : mem[ra_b];
  assign rd_c = (ra_c == PCI) ? pc_view : mem[ra_c];

  // R11
  pc_never_written_chk: assert property (@(posedge clk) we |-> (wa != PCI));
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import agu_pkg::*;
#(
  parameter int unsigned W       = XLEN,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned PC_AHEAD = 8,
  localparam int unsigned AW     = $clog2(NREGS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  instr,
  input  logic [W-1:0] instr_addr,
  input  logic [3:0]   flags,
  output logic         done,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);
  localparam logic [AW-1:0] PCI = AW'(NREGS - 1);

  agu_state_e   state;
  logic [31:0]  instr_q;
  logic [W-1:0] pc_q;
  logic [3:0]   flags_q;
  agu_fields_t  fld;

  logic [W-1:0] base_val, index_val, data_val;
  logic [W-1:0] acc_addr, upd_addr;

  logic          wb_pend, ld_pend;
  logic [AW-1:0] wb_reg, ld_reg;
  logic [W-1:0]  wb_val;

  logic          rf_we;
  logic [AW-1:0] rf_wa;
  logic [W-1:0]  rf_wd;

  agu_decode u_dec (
    .instr (instr_q),
    .flags (flags_q),
    .fld   (fld)
  );

  agu_regfile #(.W(W), .ENTRIES(NREGS)) u_rf (
    .clk     (clk),
    .pc_view (pc_q + W'(PC_AHEAD)),
    .ra_a    (AW'(fld.rn)),
    .ra_b    (AW'(fld.rm)),
    .ra_c    (AW'(fld.rd)),
    .rd_a    (base_val),
    .rd_b    (index_val),
    .rd_c    (data_val),
    .we      (rf_we),
    .wa      (rf_wa),
    .wd      (rf_wd)
  );

  agu_addr #(.W(W)) u_addr (
    .base         (base_val),
    .index        (index_val),
    .reg_off      (fld.reg_off),
    .up           (fld.up),
    .pre          (fld.pre),
    .imm          (fld.imm),
    .shamt        (fld.shamt),
    .access_addr  (acc_addr),
    .updated_addr (upd_addr)
  );

  assign in_ready = (state == ST_IDLE);

  // single write port: base update in ST_MEM, load data in ST_RESP
  always_comb begin
    rf_we = 1'b0;
    rf_wa = wb_reg;
    rf_wd = wb_val;
    if (state == ST_MEM && wb_pend) begin
      rf_we = 1'b1;
    end else if (state == ST_RESP && ld_pend) begin
      rf_we = 1'b1;
      rf_wa = ld_reg;
      rf_wd = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      wb_pend <= 1'b0;
      ld_pend <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (in_valid) begin
          instr_q <= instr;
          pc_q    <= instr_addr;
          flags_q <= flags;
          state   <= ST_EXEC;
        end
        ST_EXEC: begin
          if (fld.cond_ok) begin
            mem_req   <= 1'b1;
            mem_we    <= ~fld.load;
            mem_addr  <= acc_addr;
            mem_wdata <= data_val;
            wb_val    <= upd_addr;
            wb_reg    <= AW'(fld.rn);
            ld_reg    <= AW'(fld.rd);
            wb_pend   <= (~fld.pre | fld.wb) && (AW'(fld.rn) != PCI)
                         && !(fld.load && fld.rd == fld.rn);
            ld_pend   <= fld.load && (AW'(fld.rd) != PCI);
            state     <= ST_MEM;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_MEM: begin
          mem_req <= 1'b0;
          wb_pend <= 1'b0;
          state   <= ST_RESP;
        end
        default: begin
          ld_pend <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // R12
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R1
  done_means_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);
  // R1
  busy_when_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !in_ready && !done);
  // R10
  cond_fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !fld.cond_ok) |=> (!mem_req && done && !rf_we));
  // R6
  post_uses_base_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && fld.cond_ok && !fld.pre) |=> (mem_addr == $past(base_val)));
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEM && ld_pend) |-> !(rf_we && rf_wa == ld_reg));
endmodule

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [31:0] instr_addr = '0;
  logic [3:0]  flags = '0;
  logic        done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [256];
  logic [31:0] m_rf [16];

  always #2.5 clk = ~clk;

  ldst_agu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .instr_addr(instr_addr), .flags(flags), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_ref(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0: return z;       4'd1: return !z;
      4'd2: return cy;      4'd3: return !cy;
      4'd4: return n;       4'd5: return !n;
      4'd6: return v;       4'd7: return !v;
      4'd8: return cy && !z;  4'd9: return !cy || z;
      4'd10: return n == v;   4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] c, input bit i, input bit p,
      input bit u, input bit w, input bit l, input logic [3:0] rn,
      input logic [3:0] rd, input logic [11:0] low);
    return {c, 2'b01, i, p, u, 1'b0, w, l, rn, rd, low};
  endfunction

  function automatic logic [31:0] rv(input logic [3:0] r, input logic [31:0] pc);
    return (r == 4'd15) ? pc + 32'd8 : m_rf[r];
  endfunction

  task automatic exec(input logic [31:0] ins, input logic [31:0] pc,
                      input logic [3:0] fl, input string atag);
    logic [3:0] rn = ins[19:16], rd = ins[15:12], rm = ins[3:0];
    bit i = ins[25], p = ins[24], u = ins[23], w = ins[21], l = ins[20];
    bit pass = cond_ref(ins[31:28], fl);
    logic [31:0] base = rv(rn, pc);
    logic [31:0] off = i ? (rv(rm, pc) << ins[11:7]) : {20'd0, ins[11:0]};
    logic [31:0] sum = u ? base + off : base - off;
    logic [31:0] ea = p ? sum : base;
    logic [31:0] sdat = rv(rd, pc);
    logic [31:0] ldat;
    chk(in_ready === 1'b1, "R1", "in_ready before issue", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; instr = ins; instr_addr = pc; flags = fl;
    @(negedge clk);
    in_valid = 1'b0; instr = $urandom; flags = 4'($urandom);
    chk(in_ready === 1'b0 && mem_req === 1'b0, "R1", "busy after accept",
        {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    if (!pass) begin
      chk(mem_req === 1'b0, "R10", "request on failed condition", {31'd0, mem_req}, 32'd0);
      chk(done === 1'b1, "R10", "done on failed condition", {31'd0, done}, 32'd1);
      return;
    end
    chk(mem_req === 1'b1, "R12", "mem_req", {31'd0, mem_req}, 32'd1);
    chk(mem_addr === ea, atag, "mem_addr", mem_addr, ea);
    chk(mem_we === !l, "R8", "mem_we", {31'd0, mem_we}, {31'd0, !l});
    if (!l) chk(mem_wdata === sdat, "R8", "mem_wdata", mem_wdata, sdat);
    ldat = mem[ea[9:2]];
    @(negedge clk);
    chk(mem_req === 1'b0 && done === 1'b0, "R12", "req/done after access",
        {30'd0, mem_req, done}, 32'd0);
    @(negedge clk);
    chk(done === 1'b1 && in_ready === 1'b1, "R1", "done pulse", {30'd0, done, in_ready}, 32'd3);
    if ((!p || w) && rn != 4'd15 && !(l && rd == rn)) m_rf[rn] = sum;
    if (l && rd != 4'd15) m_rf[rd] = ldat;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 256; k++) mem[k] = $urandom;
    for (int k = 0; k < 16; k++) m_rf[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(in_ready === 1'b1, "R1", "reset in_ready", {31'd0, in_ready}, 32'd1);
    chk(done === 1'b0 && mem_req === 1'b0, "R12", "reset outputs", {30'd0, done, mem_req}, 32'd0);

    // bootstrap every register from memory, PC-relative (R7)
    for (int k = 0; k < 15; k++)
      exec(mk(4'hE, 0, 1, 1, 0, 1, 4'd15, 4'(k), 12'(4 * k)), 32'h0000_0100, 4'h0, "R7");

    // directed corner cases
    exec(mk(4'hE, 1, 1, 1, 1, 1, 4'd6, 4'd2, {5'd4, 2'b00, 1'b0, 4'd8}), 32'h200, 4'h0, "R4");
    exec(mk(4'hE, 0, 0, 1, 0, 1, 4'd6, 4'd2, 12'd20), 32'h204, 4'h0, "R6");
    exec(mk(4'hE, 1, 1, 0, 0, 1, 4'd6, 4'd2, 12'd8), 32'h208, 4'h0, "R3");
    exec(mk(4'hE, 0, 1, 0, 0, 0, 4'd7, 4'd9, 12'hFFC), 32'h20C, 4'h0, "R3");
    exec(mk(4'hE, 0, 0, 1, 0, 1, 4'd3, 4'd3, 12'd4), 32'h210, 4'h0, "R9");
    exec(mk(4'hE, 0, 1, 1, 0, 0, 4'd15, 4'd3, 12'd0), 32'h214, 4'h0, "R9");
    exec(mk(4'hE, 0, 1, 1, 1, 1, 4'd15, 4'd15, 12'd8), 32'h218, 4'h0, "R11");
    exec(mk(4'hE, 1, 1, 1, 0, 0, 4'd4, 4'd15, {5'd1, 3'b111, 4'd15}), 32'h21C, 4'h0, "R7");
    exec(mk(4'h0, 0, 1, 1, 1, 1, 4'd1, 4'd2, 12'd4), 32'h220, 4'b1011, "R10");
    exec(mk(4'hC, 0, 1, 1, 1, 1, 4'd1, 4'd2, 12'd4), 32'h224, 4'b1001, "R10");
    exec(mk(4'hB, 0, 1, 1, 0, 1, 4'd1, 4'd2, 12'd4), 32'h228, 4'b1000, "R10");
    exec(32'hEC9F_0070 | {12'd0, 4'd5, 4'd0, 12'd0}, 32'h22C, 4'h0, "R2");

    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [3:0] c = ($urandom % 2) ? 4'hE : 4'($urandom);
      logic [31:0] ins = mk(c, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                            1'($urandom), 4'($urandom), 4'($urandom), 12'($urandom));
      ins[27:26] = 2'($urandom);
      ins[22] = 1'($urandom);
      exec(ins, {$urandom} & 32'hFFFF_FFFC, 4'($urandom), ins[24] ? "R5" : "R6");
    end

    // dump all registers through stores
    for (int k = 0; k < 16; k++)
      exec(mk(4'hE, 0, 1, 1, 0, 0, 4'd15, 4'(k), 12'd0), 32'h300, 4'h0, "R8");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule